// File: doc/BRIEF.md
# Pad Output Path Cell

This block forms the output half of a configurable I/O cell for a group of pads that share one configuration. Each lane takes two routed data signals and a 3-state control. A shared output register, with a clock enable and a local set/reset, can sit in the path. The cell produces a pad data value and a pad output-enable for each lane. Configuration inputs are expected to stay static while the block runs. They select the register's data source and its clock. They also select how the local set/reset behaves, whether the pad takes the register or the raw first data input, the data and enable polarity, and an open-drain mode.

In open-drain mode the data value steers the output-enable. A lane can therefore pull its pad low or release it, but it never drives a high level. One enable code turns a lane off entirely. In that code the pad stays 3-stated whatever else is selected.

Top module: `pad_out_cell`

## Requirements
- R1: The register's D value per lane is selected by `cfg_dsrc`: 0 = `out1`, 1 = `out2`, 2 = constant 1, 3 = constant 0, and is then inverted when `cfg_d_inv` is 1.
- R2: The register updates only on the rising edge of the clock picked by `cfg_clk_sel` (0 = `clk_sys`, 1 = `clk_fast`); edges of the other clock leave it unchanged.
- R3: With `cfg_use_reg` = 1 the pad value comes from the register; with 0 it follows `out1` combinationally, within the same cycle.
- R4: With `cfg_out_inv` = 1 the pad value is the inverse of the selected source.
- R5: `cfg_oe_mode` sets the enable per lane: 0 = enabled when `ts` is 1, 1 = enabled when `ts` is 0, 2 = always enabled, 3 = never enabled (3-stated, overriding every other setting).
- R6: With `cfg_od` = 1 (and mode not 3), a pad value of 0 gives `pad_oe` = 1 with `pad_data` = 0, a pad value of 1 gives `pad_oe` = 0, and `ts` has no effect; `pad_oe` and `pad_data` are never both 1.
- R7: `pad_data` is 0 on every lane whose `pad_oe` is 0.
- R8: The local set/reset loads every lane with the value of `cfg_set_val` (1 = set, 0 = clear).
- R9: With `cfg_lsr_async` = 1, `lsr` at 1 forces the register to the set/reset value at once, without a clock edge and regardless of `ce`.
- R10: Synchronous set/reset with `cfg_ce_first` = 0: `lsr` at 1 on a clock edge loads the set/reset value whatever `ce` is.
- R11: Synchronous set/reset with `cfg_ce_first` = 1: `lsr` acts only on an edge where `ce` is 1; with `ce` at 0 the register holds.
- R12: With `lsr` at 0, a clock edge loads D when `ce` is 1 and holds the register when `ce` is 0.
- R13: `rst_n` at 0 on an edge of the selected clock clears the register to 0, unless an asynchronous set/reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| clk_fast | input | 1 | Per-cell fast clock |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| out1 | input | LANES | First routed data input |
| out2 | input | LANES | Second routed data input |
| ts | input | LANES | 3-state control per lane |
| ce | input | 1 | Register clock enable |
| lsr | input | 1 | Local set/reset |
| cfg_clk_sel | input | 1 | Register clock select |
| cfg_dsrc | input | 2 | Register data source |
| cfg_d_inv | input | 1 | Invert register D |
| cfg_set_val | input | 1 | Value loaded by set/reset |
| cfg_lsr_async | input | 1 | Asynchronous set/reset |
| cfg_ce_first | input | 1 | Clock enable takes priority over set/reset |
| cfg_use_reg | input | 1 | Pad value from register (1) or from out1 (0) |
| cfg_out_inv | input | 1 | Invert pad value |
| cfg_oe_mode | input | 2 | Output-enable mode |
| cfg_od | input | 1 | Open-drain mode |
| pad_data | output | LANES | Pad data value |
| pad_oe | output | LANES | Pad output-enable |

## Verification
The enable and pad value paths are combinational. Their results are due in the same cycle as the stimulus, so the bench samples them one nanosecond after it drives inputs, which is before the next rising edge. Register results become visible after the first rising edge of the selected clock. The bench samples them at the following falling edge, or one nanosecond after a manual fast-clock pulse. An asynchronous set/reset is due at once and is checked in the same sample as the combinational paths.

// File: rtl/pad_out_pkg.sv
// Shared encodings for the pad output path cell.
// Assumes configuration fields are held static during operation.
package pad_out_pkg;

    // Source of the output register's D input.
    typedef enum logic [1:0] {
        DSRC_OUT1 = 2'd0,
        DSRC_OUT2 = 2'd1,
        DSRC_ONE  = 2'd2,
        DSRC_ZERO = 2'd3
    } dsrc_e;

    // How the pad output-enable is derived.
    typedef enum logic [1:0] {
        OE_TS_HIGH = 2'd0,
        OE_TS_LOW  = 2'd1,
        OE_ON      = 2'd2,
        OE_OFF     = 2'd3
    } oe_mode_e;

endpackage

// File: rtl/pad_out_dsel.sv
// Data selector for the output register.
// Picks one of two routed inputs or a constant per lane, then applies an
// optional inversion. Purely combinational; assumes a static select.
module pad_out_dsel
    import pad_out_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] out1,
    input  logic [LANES-1:0] out2,
    input  dsrc_e            sel,
    input  logic             inv,
    output logic [LANES-1:0] d
);

    logic [LANES-1:0] raw;

    // Choose the raw source for every lane.
    always_comb begin
        unique case (sel)
            DSRC_OUT1: raw = out1;
            DSRC_OUT2: raw = out2;
            DSRC_ONE:  raw = '1;
            default:   raw = '0;
        endcase
    end

    // Apply the optional D inversion.
    assign d = inv ? ~raw : raw;

endmodule

// File: rtl/pad_out_ff.sv
// Output register with clock select, clock enable and local set/reset.
// The set/reset is synchronous or asynchronous, and in synchronous form its
// priority against the clock enable is selectable. rst_n is a synchronous
// active-low clear on the selected clock. Assumes cfg_clk_sel changes only
// while both clocks are low, so the clock mux makes no spurious edge.
module pad_out_ff #(
    parameter int LANES = 4
) (
    input  logic             clk_sys,
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             cfg_clk_sel,
    input  logic             cfg_lsr_async,
    input  logic             cfg_ce_first,
    input  logic             cfg_set_val,
    input  logic             ce,
    input  logic             lsr,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);

    logic             reg_clk;
    logic             async_hit;
    logic [LANES-1:0] set_word;

    // Register clock picked from the two sources.
    assign reg_clk   = cfg_clk_sel ? clk_fast : clk_sys;
    // Asynchronous set/reset fires only when that style is chosen.
    assign async_hit = cfg_lsr_async & lsr;
    // Value every lane takes on set/reset.
    assign set_word  = {LANES{cfg_set_val}};

    // Register update: async set/reset, sync clear, then the sync priority rules.
    always_ff @(posedge reg_clk or posedge async_hit) begin
        if (async_hit) begin
            q <= set_word;
        end else if (!rst_n) begin
            q <= '0;
        end else if (cfg_lsr_async) begin
            if (ce) q <= d;
        end else if (cfg_ce_first) begin
            if (ce) q <= lsr ? set_word : d;
        end else if (lsr) begin
            q <= set_word;
        end else if (ce) begin
            q <= d;
        end
    end

    // R9: an active asynchronous set/reset is visible at any edge.
    a_r9_async_forces: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (cfg_lsr_async && lsr) |-> (q == set_word));

    // R10: set/reset wins over a low clock enable.
    a_r10_lsr_over_ce: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (!cfg_lsr_async && !cfg_ce_first && lsr) |=> ((q == set_word) || cfg_lsr_async));

    // R11: with clock enable first, a low enable holds even under set/reset.
    a_r11_ce_gates_lsr: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (!cfg_lsr_async && cfg_ce_first && !ce) |=> ($stable(q) || cfg_lsr_async));

    // R12: idle inputs keep the register value.
    a_r12_hold: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (!cfg_lsr_async && !ce && !lsr) |=> ($stable(q) || cfg_lsr_async));

endmodule

// File: rtl/pad_out_drive.sv
// Per-lane pad driver logic.
// Selects the pad source, applies inversion and derives the output-enable
// from the 3-state control, the open-drain mode or the fixed modes. The pad
// data is forced to 0 whenever the lane is not enabled. Combinational.
module pad_out_drive
    import pad_out_pkg::*;
(
    input  logic     q_bit,
    input  logic     out1_bit,
    input  logic     ts_bit,
    input  logic     use_reg,
    input  logic     out_inv,
    input  oe_mode_e oe_mode,
    input  logic     od,
    output logic     pad_d,
    output logic     pad_e
);

    logic value;
    logic enable;

    // Pad value before the enable gating.
    assign value = (use_reg ? q_bit : out1_bit) ^ out_inv;

    // Output-enable: off mode overrides, open-drain uses the value itself.
    always_comb begin
        if (oe_mode == OE_OFF) begin
            enable = 1'b0;
        end else if (od) begin
            enable = ~value;
        end else begin
            unique case (oe_mode)
                OE_TS_HIGH: enable = ts_bit;
                OE_TS_LOW:  enable = ~ts_bit;
                default:    enable = 1'b1;
            endcase
        end
    end

    // Drive data only when enabled, and only 0 in open-drain mode.
    assign pad_e = enable;
    assign pad_d = enable & ~od & value;

endmodule

// File: rtl/pad_out_cell.sv
// Pad output path cell for a group of LANES pads sharing one configuration.
// Chains the register data selector, the output register and one driver per
// lane. Assumes the cfg_* inputs are static during operation.
module pad_out_cell
    import pad_out_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk_sys,
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic [LANES-1:0] out1,
    input  logic [LANES-1:0] out2,
    input  logic [LANES-1:0] ts,
    input  logic             ce,
    input  logic             lsr,
    input  logic             cfg_clk_sel,
    input  logic [1:0]       cfg_dsrc,
    input  logic             cfg_d_inv,
    input  logic             cfg_set_val,
    input  logic             cfg_lsr_async,
    input  logic             cfg_ce_first,
    input  logic             cfg_use_reg,
    input  logic             cfg_out_inv,
    input  logic [1:0]       cfg_oe_mode,
    input  logic             cfg_od,
    output logic [LANES-1:0] pad_data,
    output logic [LANES-1:0] pad_oe
);

    logic [LANES-1:0] reg_d;
    logic [LANES-1:0] reg_q;
    oe_mode_e         oe_mode;

    assign oe_mode = oe_mode_e'(cfg_oe_mode);

    // Register data source.
    pad_out_dsel #(.LANES(LANES)) u_dsel (
        .out1 (out1),
        .out2 (out2),
        .sel  (dsrc_e'(cfg_dsrc)),
        .inv  (cfg_d_inv),
        .d    (reg_d)
    );

    // Shared output register.
    pad_out_ff #(.LANES(LANES)) u_ff (
        .clk_sys       (clk_sys),
        .clk_fast      (clk_fast),
        .rst_n         (rst_n),
        .cfg_clk_sel   (cfg_clk_sel),
        .cfg_lsr_async (cfg_lsr_async),
        .cfg_ce_first  (cfg_ce_first),
        .cfg_set_val   (cfg_set_val),
        .ce            (ce),
        .lsr           (lsr),
        .d             (reg_d),
        .q             (reg_q)
    );

    // One driver per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pad_out_drive u_drv (
            .q_bit    (reg_q[i]),
            .out1_bit (out1[i]),
            .ts_bit   (ts[i]),
            .use_reg  (cfg_use_reg),
            .out_inv  (cfg_out_inv),
            .oe_mode  (oe_mode),
            .od       (cfg_od),
            .pad_d    (pad_data[i]),
            .pad_e    (pad_oe[i])
        );
    end

    // R6: open-drain never drives a high level.
    a_r6_od_no_high: assert property (@(posedge clk_sys) disable iff (!rst_n)
        cfg_od |-> ((pad_oe & pad_data) == '0));

    // R5: the off mode keeps every lane 3-stated.
    a_r5_off_hiz: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cfg_oe_mode == 2'd3) |-> (pad_oe == '0));

    // R7: no data on a disabled lane.
    a_r7_quiet_when_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
        ((pad_data & ~pad_oe) == '0));

    // R5: always-on mode enables every lane.
    a_r5_on_all: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cfg_oe_mode == 2'd2 && !cfg_od) |-> (pad_oe == '1));

endmodule

// File: tb/sim_pad_out_cell.sv
`timescale 1ns/100ps
module sim_pad_out_cell;
    localparam int L = 4;

    logic clk_sys = 1'b0;
    logic clk_fast = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0] out1 = '0, out2 = '0, ts = '0;
    logic ce = 1'b0, lsr = 1'b0;
    logic cfg_clk_sel = 1'b0, cfg_d_inv = 1'b0, cfg_set_val = 1'b0;
    logic cfg_lsr_async = 1'b0, cfg_ce_first = 1'b0, cfg_use_reg = 1'b1;
    logic cfg_out_inv = 1'b0, cfg_od = 1'b0;
    logic [1:0] cfg_dsrc = 2'd0, cfg_oe_mode = 2'd2;
    logic [L-1:0] pad_data, pad_oe;
    logic [L-1:0] eq = '0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk_sys = ~clk_sys;

    pad_out_cell #(.LANES(L)) u0 (
        .clk_sys(clk_sys), .clk_fast(clk_fast), .rst_n(rst_n),
        .out1(out1), .out2(out2), .ts(ts), .ce(ce), .lsr(lsr),
        .cfg_clk_sel(cfg_clk_sel), .cfg_dsrc(cfg_dsrc), .cfg_d_inv(cfg_d_inv),
        .cfg_set_val(cfg_set_val), .cfg_lsr_async(cfg_lsr_async),
        .cfg_ce_first(cfg_ce_first), .cfg_use_reg(cfg_use_reg),
        .cfg_out_inv(cfg_out_inv), .cfg_oe_mode(cfg_oe_mode), .cfg_od(cfg_od),
        .pad_data(pad_data), .pad_oe(pad_oe)
    );

    // Expected register D (R1).
    function automatic logic [L-1:0] d_exp();
        logic [L-1:0] r;
        case (cfg_dsrc)
            2'd0: r = out1;
            2'd1: r = out2;
            2'd2: r = '1;
            default: r = '0;
        endcase
        return cfg_d_inv ? ~r : r;
    endfunction

    // Expected register value after an edge (R8..R13).
    function automatic logic [L-1:0] q_next(input logic [L-1:0] q);
        logic [L-1:0] sv;
        sv = {L{cfg_set_val}};
        if (cfg_lsr_async && lsr) return sv;
        if (!rst_n) return '0;
        if (cfg_lsr_async) return ce ? d_exp() : q;
        if (cfg_ce_first) begin
            if (!ce) return q;
            return lsr ? sv : d_exp();
        end
        if (lsr) return sv;
        return ce ? d_exp() : q;
    endfunction

    // Compare pads against values derived from R3..R7.
    task automatic chk(input string tag);
        logic [L-1:0] eo, ed;
        for (int i = 0; i < L; i++) begin
            logic v;
            v = (cfg_use_reg ? eq[i] : out1[i]) ^ cfg_out_inv;
            if (cfg_oe_mode == 2'd3) eo[i] = 1'b0;
            else if (cfg_od) eo[i] = ~v;
            else if (cfg_oe_mode == 2'd0) eo[i] = ts[i];
            else if (cfg_oe_mode == 2'd1) eo[i] = ~ts[i];
            else eo[i] = 1'b1;
            ed[i] = eo[i] & ~cfg_od & v;
        end
        n_chk++;
        if (pad_oe !== eo || pad_data !== ed) begin
            n_bad++;
            $display("FAIL %s: pad_oe=%b pad_data=%b expected pad_oe=%b pad_data=%b",
                     tag, pad_oe, pad_data, eo, ed);
        end
    endtask

    // One system-clock cycle: combinational check, edge, registered check.
    task automatic cycle(input string tag);
        #1;
        if (cfg_lsr_async && lsr) eq = {L{cfg_set_val}};
        chk(tag);
        if (!cfg_clk_sel) eq = q_next(eq);
        @(posedge clk_sys);
        @(negedge clk_sys);
        chk(tag);
    endtask

    // One manual fast-clock pulse (R2).
    task automatic fast_pulse(input string tag);
        #1;
        chk(tag);
        eq = q_next(eq);
        clk_fast = 1'b1;
        #1;
        chk(tag);
        clk_fast = 1'b0;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_sys);
        chk("R13 reset state");
        rst_n = 1'b1;

        // R1: every source with and without inversion.
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_dsrc = 2'(s); cfg_d_inv = v[0];
                out1 = 4'b1010; out2 = 4'b0110; ce = 1'b1;
                cycle("R1");
            end
        end
        cfg_dsrc = 2'd0; cfg_d_inv = 1'b0;
        // R12: hold with ce low, load with ce high.
        ce = 1'b0; out1 = 4'b0101; cycle("R12");
        ce = 1'b1; cycle("R12");
        // R3: combinational path from out1.
        cfg_use_reg = 1'b0; out1 = 4'b0011; cycle("R3");
        // R4: pad inversion.
        cfg_out_inv = 1'b1; cycle("R4"); cfg_out_inv = 1'b0;
        // R5: every enable mode.
        for (int m = 0; m < 4; m++) begin
            cfg_oe_mode = 2'(m); ts = 4'b0101; cycle("R5");
        end
        // R6: open drain, ts ignored, off mode still wins.
        cfg_od = 1'b1; cfg_oe_mode = 2'd0; ts = 4'b1001; out1 = 4'b1100; cycle("R6");
        cfg_oe_mode = 2'd3; cycle("R6");
        cfg_od = 1'b0;
        // R7: disabled lanes carry no data.
        cfg_oe_mode = 2'd0; ts = 4'b0011; out1 = 4'b1111; cycle("R7");
        cfg_use_reg = 1'b1; cfg_oe_mode = 2'd2;
        // R10: set/reset over ce.
        ce = 1'b0; out1 = 4'b0000; cycle("R10");
        cfg_set_val = 1'b1; lsr = 1'b1; cycle("R10");
        lsr = 1'b0; ce = 1'b1; cycle("R10");
        // R11: ce gates set/reset.
        cfg_ce_first = 1'b1; lsr = 1'b1; ce = 1'b0; cycle("R11");
        ce = 1'b1; cycle("R11");
        lsr = 1'b0; cfg_ce_first = 1'b0;
        // R8: clearing value.
        cfg_set_val = 1'b0; lsr = 1'b1; cycle("R8"); lsr = 1'b0;
        // R9: asynchronous set mid-cycle.
        ce = 1'b0; cfg_lsr_async = 1'b1; cfg_set_val = 1'b1; cycle("R9");
        lsr = 1'b1; cycle("R9");
        lsr = 1'b0; cycle("R9");
        cfg_lsr_async = 1'b0; cfg_set_val = 1'b0;
        // R13: reset in the middle of operation.
        ce = 1'b1; out1 = 4'b1111; cycle("R13");
        rst_n = 1'b0; cycle("R13"); rst_n = 1'b1;
        // R2: fast clock drives the register, system clock does not.
        ce = 1'b0; cycle("R2");
        cfg_clk_sel = 1'b1; out1 = 4'b0101; ce = 1'b1;
        cycle("R2"); cycle("R2");
        fast_pulse("R2");
        out1 = 4'b1001; fast_pulse("R2");
        ce = 1'b0;
        @(negedge clk_sys);
        cfg_clk_sel = 1'b0;

        // Random mix with periodic static-config changes.
        for (int k = 0; k < 3000; k++) begin
            if (k % 40 == 0) begin
                lsr = 1'b0; ce = 1'b0; rst_n = 1'b1;
                cycle("R12 cfg");
                {cfg_dsrc, cfg_d_inv, cfg_set_val, cfg_lsr_async, cfg_ce_first,
                 cfg_use_reg, cfg_out_inv, cfg_oe_mode, cfg_od} = 11'($urandom);
                cycle("R12 cfg");
            end
            out1 = 4'($urandom); out2 = 4'($urandom); ts = 4'($urandom);
            ce = 1'($urandom);
            lsr = ($urandom % 4) == 0;
            rst_n = ($urandom % 64) != 0;
            cycle("R1/R3/R5/R6/R10/R11 random");
        end
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule